// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block services a translation-buffer miss. A miss request carries a virtual page number. The walker turns that number into the physical address of one page table entry: a base register plus the page number times the four-byte entry size. It reads that entry over a valid/ready memory port and waits for the response, then decides the outcome from the entry's present bit.

If the page is present, the walker returns the physical page number and the status bits, so that the translation buffer can be filled and the access retried. If the page is absent, it reports a page fault carrying the faulting virtual address. When a present entry has its referenced bit clear, the walker first writes the entry back with that bit set, and only then reports completion.

The base register can only be loaded while the supervisor input is high. Pages are 4 KB, so the low twelve virtual address bits never take part in the walk.

Top module: `pte_walker`

## Requirements
- R1: After reset the walker is idle. `reqReady` is 1, while `memReqValid` and `doneValid` are 0. The base register holds 0, so the first walk with no base write reads address vpn*4.
- R2: A write with `baseWrEn`=1 loads `baseWrData` into the base register only when `supervisor`=1. With `supervisor`=0 the write is ignored and later walks still use the old base.
- R3: The entry address is base + vpn*4, modulo 2^32. It is fixed when the request is accepted, so a base write during a walk affects only later walks.
- R4: Each walk issues exactly one read (`memReqWrite`=0). `memReqValid`, `memReqAddr` and `memReqWrite` stay unchanged until `memReqReady` is seen.
- R5: Entry bits are: bit 0 present, bit 1 referenced, bit 2 dirty, bits 31:12 physical page number. If the entry is present and bit 1 is 0, the walker writes the entry with bit 1 set back to the same address, once, before `doneValid`.
- R6: If the entry is present and bit 1 is 1, no write is issued.
- R7: For a present entry, the completion has `doneFault`=0, `donePpn`=entry[31:12], `doneRef`=1 and `doneDirty`=entry[2].
- R8: For an absent entry (bit 0 = 0), the completion has `doneFault`=1 and `faultAddr`={vpn, 12'h000}, and no write is issued.
- R9: A request is accepted only while `reqReady` is 1, which is only in the idle state. Requests raised during a walk are ignored.
- R10: `doneValid` is a single-cycle pulse per walk, after which `reqReady` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supervisor | input | 1 | Privileged mode; gates base register writes |
| baseWrEn | input | 1 | Base register write strobe |
| baseWrData | input | 32 | New page table base address |
| reqValid | input | 1 | Miss request valid |
| reqReady | output | 1 | Walker idle, request can be taken |
| reqVpn | input | 20 | Virtual page number of the miss |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqAddr | output | 32 | Entry address |
| memReqWdata | output | 32 | Entry data for the write-back |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data (page table entry) |
| doneValid | output | 1 | Walk complete, one cycle |
| doneFault | output | 1 | Page absent |
| donePpn | output | 20 | Physical page number |
| doneRef | output | 1 | Referenced bit of the filled entry |
| doneDirty | output | 1 | Dirty bit of the filled entry |
| faultAddr | output | 32 | Faulting virtual address |

## Verification
A corrupted latched address appears on the very next read request as the wrong `memReqAddr`, and the bench compares every read against base + vpn*4. A wrong captured entry or a wrong decision state shows at the completion pulse, a few cycles later, in several ways: a wrong page number, a missing or extra write-back, or a wrong fault flag. A controller that is stuck or skips states shows either as `reqReady` staying low, which trips the walk timeout, or as `doneValid` lasting longer than one cycle.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int PresentBit = 0;
  localparam int RefBit     = 1;
  localparam int DirtyBit   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_REQ,
    ST_READ_WAIT,
    ST_UPDATE,
    ST_DONE
  } walkState_t;

  typedef struct packed {
    logic captureReq;
    logic capturePte;
    logic setRef;
  } walkStrobes_t;
endpackage

// File: rtl/walk_datapath.sv
module walk_datapath
  import walk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PTE_W       = 32,
  parameter int PAGE_BITS   = 12,
  parameter int ENTRY_BYTES = 4,
  localparam int VPN_W       = ADDR_W - PAGE_BITS,
  localparam int PPN_W       = PTE_W - PAGE_BITS,
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               supervisor,
  input  logic               baseWrEn,
  input  logic [ADDR_W-1:0]  baseWrData,
  input  logic [VPN_W-1:0]   reqVpn,
  input  logic [PTE_W-1:0]   memRspData,
  input  walkStrobes_t       strobes,
  output logic               pteValid,
  output logic               pteRef,
  output logic [ADDR_W-1:0]  entryAddr,
  output logic [PTE_W-1:0]   entryData,
  output logic [PPN_W-1:0]   donePpn,
  output logic               doneRef,
  output logic               doneDirty,
  output logic [ADDR_W-1:0]  faultAddr
);
  logic [ADDR_W-1:0] baseReg;
  logic [VPN_W-1:0]  vpnReg;
  logic [ADDR_W-1:0] addrReg;
  logic [PTE_W-1:0]  pteReg;
  logic [PTE_W-1:0]  refMask;

  assign refMask = PTE_W'(1) << RefBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      vpnReg  <= '0;
      addrReg <= '0;
      pteReg  <= '0;
    end else begin
      if (baseWrEn && supervisor) begin
        baseReg <= baseWrData;
      end
      if (strobes.captureReq) begin
        vpnReg  <= reqVpn;
        addrReg <= baseReg + (ADDR_W'(reqVpn) << ENTRY_SHIFT);
      end
      if (strobes.capturePte) begin
        pteReg <= strobes.setRef ? (memRspData | refMask) : memRspData;
      end
    end
  end

  assign pteValid  = memRspData[PresentBit];
  assign pteRef    = memRspData[RefBit];
  assign entryAddr = addrReg;
  assign entryData = pteReg;
  assign donePpn   = pteReg[PTE_W-1:PAGE_BITS];
  assign doneRef   = pteReg[RefBit];
  assign doneDirty = pteReg[DirtyBit];
  assign faultAddr = {vpnReg, {PAGE_BITS{1'b0}}};

  // R2: user-mode writes leave the base untouched
  assert_base_user_R2: assert property (@(posedge clk) disable iff (!rstN)
    (baseWrEn && !supervisor) |=> $stable(baseReg));

  // R3: the latched address only moves when a request is captured
  assert_addr_latched_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureReq |=> $stable(addrReg));
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic         pteValid,
  input  logic         pteRef,
  output walkStrobes_t strobes,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         memReqWrite,
  output logic         doneValid,
  output logic         doneFault
);
  walkState_t state, stateNext;
  logic faultReg, faultNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      faultReg <= 1'b0;
    end else begin
      state    <= stateNext;
      faultReg <= faultNext;
    end
  end

  always_comb begin
    stateNext = state;
    faultNext = faultReg;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.captureReq = 1'b1;
          faultNext          = 1'b0;
          stateNext          = ST_READ_REQ;
        end
      end
      ST_READ_REQ: begin
        if (memReqReady) stateNext = ST_READ_WAIT;
      end
      ST_READ_WAIT: begin
        if (memRspValid) begin
          strobes.capturePte = 1'b1;
          if (!pteValid) begin
            faultNext = 1'b1;
            stateNext = ST_DONE;
          end else if (!pteRef) begin
            strobes.setRef = 1'b1;
            stateNext      = ST_UPDATE;
          end else begin
            stateNext = ST_DONE;
          end
        end
      end
      ST_UPDATE: begin
        if (memReqReady) stateNext = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_READ_REQ) || (state == ST_UPDATE);
  assign memReqWrite = (state == ST_UPDATE);
  assign doneValid   = (state == ST_DONE);
  assign doneFault   = faultReg;

  // R10: completion lasts one cycle and the walker then goes idle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));

  // R9: once a request is taken, no other is taken on the next cycle
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R1: nothing is issued out of reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (reqReady && !memReqValid && !doneValid));
endmodule

// File: rtl/pte_walker.sv
module pte_walker
  import walk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PTE_W       = 32,
  parameter int PAGE_BITS   = 12,
  parameter int ENTRY_BYTES = 4,
  localparam int VPN_W = ADDR_W - PAGE_BITS,
  localparam int PPN_W = PTE_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supervisor,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VPN_W-1:0]  reqVpn,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [PTE_W-1:0]  memReqWdata,
  input  logic              memRspValid,
  input  logic [PTE_W-1:0]  memRspData,
  output logic              doneValid,
  output logic              doneFault,
  output logic [PPN_W-1:0]  donePpn,
  output logic              doneRef,
  output logic              doneDirty,
  output logic [ADDR_W-1:0] faultAddr
);
  walkStrobes_t strobes;
  logic pteValid, pteRef;

  walk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .pteValid    (pteValid),
    .pteRef      (pteRef),
    .strobes     (strobes),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .doneValid   (doneValid),
    .doneFault   (doneFault)
  );

  walk_datapath #(
    .ADDR_W      (ADDR_W),
    .PTE_W       (PTE_W),
    .PAGE_BITS   (PAGE_BITS),
    .ENTRY_BYTES (ENTRY_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .supervisor (supervisor),
    .baseWrEn   (baseWrEn),
    .baseWrData (baseWrData),
    .reqVpn     (reqVpn),
    .memRspData (memRspData),
    .strobes    (strobes),
    .pteValid   (pteValid),
    .pteRef     (pteRef),
    .entryAddr  (memReqAddr),
    .entryData  (memReqWdata),
    .donePpn    (donePpn),
    .doneRef    (doneRef),
    .doneDirty  (doneDirty),
    .faultAddr  (faultAddr)
  );

  // R4: a pending memory request holds until accepted
  assert_hold_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));

  // R5: a write-back always carries a present entry with the referenced bit set
  assert_wb_ref_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |->
      (memReqWdata[RefBit] && memReqWdata[PresentBit]));

  // R7: a fill always reports the referenced bit as set
  assert_fill_ref_R7: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !doneFault) |-> doneRef);
endmodule

// File: tb/pte_walker_test.sv
module pte_walker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        supervisor = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [19:0] reqVpn = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic        memReqWrite;
  logic [31:0] memReqAddr;
  logic [31:0] memReqWdata;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        doneValid;
  logic        doneFault;
  logic [19:0] donePpn;
  logic        doneRef;
  logic        doneDirty;
  logic [31:0] faultAddr;

  int checks = 0;
  int errors = 0;
  bit summaryDone = 0;

  logic [31:0] mem [1024];
  int rdCount = 0;
  int wrCount = 0;
  logic [31:0] lastRdAddr = '0;
  logic [31:0] lastWrAddr = '0;
  logic [31:0] lastWrData = '0;
  logic [31:0] expBase = '0;

  always #5 clk = ~clk;

  pte_walker uut (.*);

  function automatic int memIdx(input logic [31:0] a);
    return int'(a[11:2]);
  endfunction

  function automatic logic [31:0] entryAddrOf(input logic [31:0] b, input logic [19:0] v);
    return b + {10'b0, v, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: decides ready and responses on falling edges
  initial begin
    int pend = 0;
    int pIdx = 0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          memRspValid = 1'b1;
          memRspData  = mem[pIdx];
        end
      end
      memReqReady = ($urandom % 3) != 0;
      if (rstN && memReqValid && memReqReady) begin
        if (memReqWrite) begin
          mem[memIdx(memReqAddr)] = memReqWdata;
          wrCount++;
          lastWrAddr = memReqAddr;
          lastWrData = memReqWdata;
        end else begin
          rdCount++;
          lastRdAddr = memReqAddr;
          pIdx = memIdx(memReqAddr);
          pend = 1 + ($urandom % 3);
        end
      end
    end
  end

  task automatic writeBase(input logic [31:0] val, input bit sup);
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = val; supervisor = sup;
    if (sup) expBase = val;
    @(negedge clk);
    baseWrEn = 1'b0; supervisor = 1'b0;
  endtask

  task automatic walk(input logic [19:0] vpn, input logic [31:0] pte,
                      input bit holdBusy, input bit midBase, input logic [31:0] midVal);
    logic [31:0] addr;
    int rd0, wr0, tmo;
    addr = entryAddrOf(expBase, vpn);
    mem[memIdx(addr)] = pte;
    @(negedge clk);
    rd0 = rdCount; wr0 = wrCount;
    chk(reqReady == 1'b1, "R10 ready before walk", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqVpn = vpn;
    @(negedge clk);
    chk(reqReady == 1'b0, "R9 busy after accept", 32'(reqReady), 32'd0);
    if (midBase) begin
      baseWrEn = 1'b1; baseWrData = midVal; supervisor = 1'b1;
    end
    if (holdBusy) begin
      reqVpn = vpn ^ 20'h5a5a5;
    end else begin
      reqValid = 1'b0;
    end
    if (midBase || holdBusy) begin
      @(negedge clk);
      baseWrEn = 1'b0; supervisor = 1'b0; reqValid = 1'b0;
      if (midBase) expBase = midVal;
    end
    tmo = 0;
    while (!doneValid && tmo < 200) begin
      @(negedge clk);
      tmo++;
    end
    chk(doneValid == 1'b1, "R10 walk completes", 32'(doneValid), 32'd1);
    chk(rdCount - rd0 == 1, "R4 one read per walk", 32'(rdCount - rd0), 32'd1);
    chk(lastRdAddr == addr, "R3 entry address", lastRdAddr, addr);
    if (!pte[0]) begin
      chk(doneFault == 1'b1, "R8 fault flag", 32'(doneFault), 32'd1);
      chk(faultAddr == {vpn, 12'h000}, "R8 fault address", faultAddr, {vpn, 12'h000});
      chk(wrCount == wr0, "R8 no write on fault", 32'(wrCount - wr0), 32'd0);
    end else begin
      chk(doneFault == 1'b0, "R7 no fault", 32'(doneFault), 32'd0);
      chk(donePpn == pte[31:12], "R7 ppn", 32'(donePpn), 32'(pte[31:12]));
      chk(doneRef == 1'b1, "R7 ref reported", 32'(doneRef), 32'd1);
      chk(doneDirty == pte[2], "R7 dirty", 32'(doneDirty), 32'(pte[2]));
      if (!pte[1]) begin
        chk(wrCount - wr0 == 1, "R5 one write-back", 32'(wrCount - wr0), 32'd1);
        chk(lastWrAddr == addr, "R5 write-back address", lastWrAddr, addr);
        chk(lastWrData == (pte | 32'h2), "R5 write-back data", lastWrData, pte | 32'h2);
      end else begin
        chk(wrCount == wr0, "R6 no write when referenced", 32'(wrCount - wr0), 32'd0);
      end
    end
    @(negedge clk);
    chk(doneValid == 1'b0, "R10 single-cycle done", 32'(doneValid), 32'd0);
    chk(reqReady == 1'b1, "R10 idle after done", 32'(reqReady), 32'd1);
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240613));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1 reset ready", 32'(reqReady), 32'd1);
    chk(memReqValid == 1'b0, "R1 reset mem idle", 32'(memReqValid), 32'd0);
    chk(doneValid == 1'b0, "R1 reset done low", 32'(doneValid), 32'd0);
    rstN = 1'b1;
    // R1: base is zero out of reset
    walk(20'h00012, 32'hABCDE001, 0, 0, '0);
    // R2: supervisor write, then ignored user write
    writeBase(32'h0004_0000, 1'b1);
    writeBase(32'h0800_0000, 1'b0);
    walk(20'h00034, 32'h12345003, 0, 0, '0);
    // R8: absent page
    walk(20'hFFFFF, 32'h7777700E, 0, 0, '0);
    // R6: already referenced, dirty
    walk(20'h00100, 32'h00F00007, 0, 0, '0);
    // R9: request held high during walk with a different vpn
    walk(20'h00200, 32'h55555001, 1, 0, '0);
    // R3: base changed mid-walk, the walk uses the old base
    walk(20'h00300, 32'h66666005, 0, 1, 32'h0010_0000);
    walk(20'h00301, 32'h66667001, 0, 0, '0);
    // R3: address wraps at 2^32
    writeBase(32'hFFFF_FFF0, 1'b1);
    walk(20'h00008, 32'h11111001, 0, 0, '0);
    for (int n = 0; n < 60; n++) begin
      logic [31:0] p;
      if (($urandom % 5) == 0) writeBase({$urandom} & 32'hFFFF_FFFC, ($urandom % 2) == 1);
      p = $urandom;
      walk(20'($urandom), p, ($urandom % 4) == 0, 0, '0);
    end
    finishRun();
  end
endmodule